// File: doc/BRIEF.md
# Parallel EEPROM Page Loader with Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. A client hands it one request: a start address, a byte count from 1 to 256 and, after acceptance, a stream of data bytes over a valid/ready handshake. The controller loads those bytes into the device one after another. Each load cycle has a programmable address setup time, write-strobe width and data hold time, all counted in clock cycles. The device starts its internal programming once the loads stop.

All bytes of one request must fall inside a single 256-byte page. A request that would spill into the next page is refused before any bus activity takes place. The device only keeps a page load open while write strobes keep arriving within a fixed window. If the byte stream stalls long enough that the next strobe could no longer meet that window, the controller aborts with an underrun error.

After the last load the controller reads the last written address again and again until the device reports that it has finished. A mode input selects one of two methods. In the first, the controller waits until the top data bit reads back true. In the second, it waits until bit 6 reads the same on two reads in a row. The result is a one-cycle done pulse or a one-cycle error pulse carrying a code. A poll timeout protects against a device that never finishes.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is asserted and when idle afterwards, req_ready is 1, ee_ce_n, ee_oe_n and ee_we_n are 1, ee_dq_oe is 0, and done and err_valid are 0.
- R2: Each byte is written to the start address plus its index in the stream. Each load holds CE low with WE high for SETUP_CYC cycles, then WE low for PULSE_CYC cycles, then WE high with CE low for HOLD_CYC cycles.
- R3: A request writes exactly req_len_m1 + 1 bytes (field value 0 means 1 byte, 255 means 256 bytes).
- R4: WE is low only while CE is low and OE is high. The data drivers (ee_dq_oe = 1) are on during the whole WE-low time and the hold time after it. They are never on while OE is low.
- R5: A poll read drives CE and OE low and WE high at the last address written. OE returns high for at least one cycle between two reads.
- R6: With poll_mode = 0, the device counts as busy while bit 7 read back differs from bit 7 of the last byte written. done follows the first read where the two match.
- R7: With poll_mode = 1, the device counts as busy while bit 6 differs between two consecutive reads. done follows the first read whose bit 6 equals that of the read before it.
- R8: A request whose low address byte plus req_len_m1 exceeds 255 is refused. err_valid is raised with err_code 1 in the cycle after acceptance, and no write strobe is issued.
- R9: Consecutive WE falling edges of one request are always fewer than LOAD_LIMIT_CYC cycles apart. If the next byte comes too late for that, the request ends with err_valid and err_code 2.
- R10: If polling lasts POLL_TIMEOUT_CYC cycles without completion, the request ends with err_valid and err_code 3.
- R11: done and err_valid are single-cycle pulses and are never high together. err_code is meaningful only while err_valid is high.
- R12: req_ready is high only while idle. A request presented while a transfer is in progress is ignored and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len_m1 | input | PAGE_BITS | Byte count minus one |
| poll_mode | input | 1 | 0: bit 7 true-data poll, 1: bit 6 toggle poll |
| byte_valid | input | 1 | Data byte present |
| byte_ready | output | 1 | Data byte taken when valid |
| byte_data | input | 8 | Data byte |
| done | output | 1 | One-cycle pulse, programming finished |
| err_valid | output | 1 | One-cycle pulse, request ended in error |
| err_code | output | 2 | 1 page cross, 2 underrun, 3 poll timeout |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_addr | output | ADDR_W | Device address |
| ee_dq_out | output | 8 | Data driven to the device |
| ee_dq_oe | output | 1 | Data driver enable |
| ee_dq_in | input | 8 | Data read from the device |

## Verification
The hardest case to reach is the edge of the inter-byte window. The client must stall long enough that the next write strobe can no longer land inside the load limit, yet the same bench must also show that a shorter stall passes. The bench injects a stall of chosen length before a chosen byte of the stream. It measures the spacing between write-strobe falling edges with a device model, so one stall length leads to an underrun and a shorter one completes. A second hard case is a read that lands exactly as the device finishes. The model keeps inverting bit 7 and toggling bit 6 while a programmable busy count runs. The bench then checks that done never appears while the model is still busy, and that it appears within a few poll periods after the model stops.

// File: rtl/epw_pkg.sv
package epw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_PULSE,
    ST_HOLD,
    ST_GAP,
    ST_READ
  } epw_state_t;

  typedef enum logic [1:0] {
    ERR_NONE       = 2'd0,
    ERR_PAGE_CROSS = 2'd1,
    ERR_UNDERRUN   = 2'd2,
    ERR_TIMEOUT    = 2'd3
  } epw_err_t;

endpackage

// File: rtl/epw_phase_timer.sv
module epw_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/epw_limit_counter.sv
module epw_limit_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic hit
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (!hit)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign hit = (cnt_q >= LIM);

endmodule

// File: rtl/epw_poll_judge.sv
module epw_poll_judge (
  input  logic mode_toggle,
  input  logic rd_bit7,
  input  logic rd_bit6,
  input  logic prev_bit6,
  input  logic have_prev,
  input  logic wr_bit7,
  output logic finished
);

  always_comb begin
    if (mode_toggle)
      finished = have_prev && (rd_bit6 == prev_bit6);
    else
      finished = (rd_bit7 == wr_bit7);
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int ADDR_W           = 17,
  parameter int PAGE_BITS        = 8,
  parameter int SETUP_CYC        = 2,
  parameter int PULSE_CYC        = 8,
  parameter int HOLD_CYC         = 2,
  parameter int READ_CYC         = 4,
  parameter int LOAD_LIMIT_CYC   = 10000,
  parameter int POLL_TIMEOUT_CYC = 700000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [PAGE_BITS-1:0] req_len_m1,
  input  logic                 poll_mode,
  input  logic                 byte_valid,
  output logic                 byte_ready,
  input  logic [7:0]           byte_data,
  output logic                 done,
  output logic                 err_valid,
  output logic [1:0]           err_code,
  output logic                 ee_ce_n,
  output logic                 ee_oe_n,
  output logic                 ee_we_n,
  output logic [ADDR_W-1:0]    ee_addr,
  output logic [7:0]           ee_dq_out,
  output logic                 ee_dq_oe,
  input  logic [7:0]           ee_dq_in
);

  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CD = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int MAX_PH = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W  = $clog2(MAX_PH + 1);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] T_READ  = TMR_W'(READ_CYC - 1);
  // Latest counter value at which a waiting byte can still be taken so that
  // the following strobe edge lands inside the load window.
  localparam int UNDER_LIM = LOAD_LIMIT_CYC - SETUP_CYC - 1;

  epw_state_t st_q, st_d;

  logic [ADDR_W-1:0]    addr_q;
  logic [PAGE_BITS-1:0] left_q;
  logic [7:0]           data_q;
  logic                 first_q;
  logic                 mode_q;
  logic                 prev6_q;
  logic                 have_prev_q;
  logic                 done_q;
  logic                 err_q;
  logic [1:0]           code_q;

  logic                 tmr_load;
  logic [TMR_W-1:0]     tmr_val;
  logic                 tmr_exp;
  logic                 gap_clear;
  logic                 gap_hit;
  logic                 poll_clear;
  logic                 poll_hit;
  logic                 poll_fin;

  logic                 take_req;
  logic                 take_byte;
  logic                 step_addr;
  logic                 sample_now;
  logic                 finish;
  logic                 err_set;
  epw_err_t             err_sel;
  logic [PAGE_BITS:0]   end_off;
  logic                 crosses;

  assign end_off = {1'b0, req_addr[PAGE_BITS-1:0]} + {1'b0, req_len_m1};
  assign crosses = end_off[PAGE_BITS];

  epw_phase_timer #(.W(TMR_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // Cycles since the most recent write-strobe falling edge.
  epw_limit_counter #(.LIMIT(UNDER_LIM)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (gap_clear),
    .hit   (gap_hit)
  );

  // Cycles spent polling.
  epw_limit_counter #(.LIMIT(POLL_TIMEOUT_CYC)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (poll_clear),
    .hit   (poll_hit)
  );

  epw_poll_judge u_judge (
    .mode_toggle (mode_q),
    .rd_bit7     (ee_dq_in[7]),
    .rd_bit6     (ee_dq_in[6]),
    .prev_bit6   (prev6_q),
    .have_prev   (have_prev_q),
    .wr_bit7     (data_q[7]),
    .finished    (poll_fin)
  );

  assign gap_clear  = (st_q == ST_ADDR) && tmr_exp;
  assign poll_clear = !((st_q == ST_GAP) || (st_q == ST_READ));

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    take_req   = 1'b0;
    take_byte  = 1'b0;
    step_addr  = 1'b0;
    sample_now = 1'b0;
    finish     = 1'b0;
    err_set    = 1'b0;
    err_sel    = ERR_NONE;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (crosses) begin
            err_set = 1'b1;
            err_sel = ERR_PAGE_CROSS;
          end else begin
            take_req = 1'b1;
            st_d     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!first_q && gap_hit) begin
          err_set = 1'b1;
          err_sel = ERR_UNDERRUN;
          st_d    = ST_IDLE;
        end else if (byte_valid) begin
          take_byte = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = T_SETUP;
          st_d      = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = T_PULSE;
          st_d     = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = T_HOLD;
          st_d     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          if (left_q == '0) begin
            tmr_load = 1'b1;
            tmr_val  = T_SETUP;
            st_d     = ST_GAP;
          end else begin
            step_addr = 1'b1;
            st_d      = ST_WAIT;
          end
        end
      end
      ST_GAP: begin
        if (poll_hit) begin
          err_set = 1'b1;
          err_sel = ERR_TIMEOUT;
          st_d    = ST_IDLE;
        end else if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = T_READ;
          st_d     = ST_READ;
        end
      end
      ST_READ: begin
        if (tmr_exp && poll_fin) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else if (poll_hit) begin
          err_set = 1'b1;
          err_sel = ERR_TIMEOUT;
          st_d    = ST_IDLE;
        end else if (tmr_exp) begin
          sample_now = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = T_SETUP;
          st_d       = ST_GAP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      data_q      <= '0;
      first_q     <= 1'b0;
      mode_q      <= 1'b0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      err_q  <= err_set;
      if (err_set)
        code_q <= err_sel;
      if (take_req) begin
        addr_q      <= req_addr;
        left_q      <= req_len_m1;
        mode_q      <= poll_mode;
        first_q     <= 1'b1;
        have_prev_q <= 1'b0;
      end
      if (take_byte) begin
        data_q  <= byte_data;
        first_q <= 1'b0;
      end
      if (step_addr) begin
        addr_q[PAGE_BITS-1:0] <= addr_q[PAGE_BITS-1:0] + 1'b1;
        left_q                <= left_q - 1'b1;
      end
      if (sample_now) begin
        prev6_q     <= ee_dq_in[6];
        have_prev_q <= 1'b1;
      end
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign byte_ready = (st_q == ST_WAIT) && (first_q || !gap_hit);
  assign done       = done_q;
  assign err_valid  = err_q;
  assign err_code   = code_q;

  assign ee_ce_n   = !((st_q == ST_ADDR) || (st_q == ST_PULSE) ||
                       (st_q == ST_HOLD) || (st_q == ST_READ));
  assign ee_we_n   = (st_q != ST_PULSE);
  assign ee_oe_n   = (st_q != ST_READ);
  assign ee_dq_oe  = (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign ee_addr   = addr_q;
  assign ee_dq_out = data_q;

endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int LOAD_LIMIT_CYC = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       err_valid,
  input logic [1:0] err_code,
  input logic       ee_ce_n,
  input logic       ee_oe_n,
  input logic       ee_we_n,
  input logic       ee_dq_oe
);

  localparam int GW = $clog2(LOAD_LIMIT_CYC + 1);
  localparam logic [GW-1:0] GLIM = GW'(LOAD_LIMIT_CYC);
  localparam logic [GW-1:0] GMAX = GW'(LOAD_LIMIT_CYC - 1);

  logic          we_prev_q;
  logic          armed_q;
  logic [GW-1:0] gap_q;
  logic          we_fall;

  assign we_fall = we_prev_q && !ee_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      armed_q   <= 1'b0;
      gap_q     <= '0;
    end else begin
      we_prev_q <= ee_we_n;
      if (req_ready)
        armed_q <= 1'b0;
      else if (we_fall)
        armed_q <= 1'b1;
      if (we_fall)
        gap_q <= '0;
      else if (gap_q != GLIM)
        gap_q <= gap_q + 1'b1;
    end
  end

  // R9: strobe falling edges of one request stay inside the load window
  assert_load_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && armed_q) |-> (gap_q < GMAX));

  // R4: strobe only with chip selected, output off and data driven
  assert_we_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n && ee_dq_oe));

  // R4: data stays driven in the cycle after the strobe rises
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_we_n) |=> (ee_we_n ? ee_dq_oe : 1'b1));

  // R5: read cycles never collide with own drivers
  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_oe_n |-> (!ee_ce_n && ee_we_n && !ee_dq_oe));

  // R5: OE rises between two poll reads
  assert_read_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_oe_n) |=> ee_oe_n);

  // R11: done is a single pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: error is a single pulse and never coincides with done
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_valid));

  // R8: a page-cross refusal leaves the bus idle and the controller ready
  assert_cross_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 2'd1) |-> (req_ready && ee_ce_n && ee_we_n));

  // R12: after acceptance the controller is busy unless the request was refused
  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready || (err_valid && err_code == 2'd1)));

endmodule

bind eeprom_page_writer epw_checker #(.LOAD_LIMIT_CYC(LOAD_LIMIT_CYC)) u_epw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .err_valid (err_valid),
  .err_code  (err_code),
  .ee_ce_n   (ee_ce_n),
  .ee_oe_n   (ee_oe_n),
  .ee_we_n   (ee_we_n),
  .ee_dq_oe  (ee_dq_oe)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;

  localparam int ADDR_W   = 17;
  localparam int PAGE_B   = 8;
  localparam int SETUP    = 2;
  localparam int PULSE    = 3;
  localparam int HOLD     = 1;
  localparam int READ     = 2;
  localparam int LOADLIM  = 40;
  localparam int POLLLIM  = 400;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [PAGE_B-1:0] req_len_m1;
  logic              poll_mode;
  logic              byte_valid;
  logic              byte_ready;
  logic [7:0]        byte_data;
  logic              done;
  logic              err_valid;
  logic [1:0]        err_code;
  logic              ee_ce_n, ee_oe_n, ee_we_n;
  logic [ADDR_W-1:0] ee_addr;
  logic [7:0]        ee_dq_out;
  logic              ee_dq_oe;
  logic [7:0]        ee_dq_in;

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_B), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .HOLD_CYC(HOLD), .READ_CYC(READ), .LOAD_LIMIT_CYC(LOADLIM),
    .POLL_TIMEOUT_CYC(POLLLIM)
  ) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .poll_mode(poll_mode),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .done(done), .err_valid(err_valid), .err_code(err_code),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
    .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe), .ee_dq_in(ee_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- device model and bus monitor ----------------
  logic [7:0]  mem [0:511];
  logic [7:0]  last_data;
  logic [8:0]  lat_addr;
  int          busy_cnt = 0;
  int          busy_len = 60;
  int          idle_cnt = 0;
  logic        tog = 1'b0;
  logic        prev_we = 1'b1;
  logic        prev_oe = 1'b1;
  logic        prev_ce = 1'b1;
  int          we_falls = 0;
  int          pre_cnt = 0;
  int          low_cnt = 0;
  int          hold_cnt = 0;
  bit          after_rise = 0;
  int          gap_cnt = 0;
  bit          have_fall = 0;
  bit          in_xfer = 0;
  logic [ADDR_W-1:0] exp_poll_addr = '0;
  logic [7:0]  rd_val;

  always_comb begin
    if (busy_cnt != 0)
      rd_val = {~last_data[7], tog, last_data[5:0]};
    else
      rd_val = mem[ee_addr[8:0]];
  end
  assign ee_dq_in = (!ee_ce_n && !ee_oe_n) ? rd_val : 8'h5A;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_cnt != 0) busy_cnt--;
      if (busy_cnt == 0) idle_cnt++; else idle_cnt = 0;
      gap_cnt++;
      // R4: no driver collision, strobe qualified
      if (!ee_oe_n && ee_dq_oe) chk(0, "R4", "driver on during read", 1, 0);
      if (!ee_we_n && (ee_ce_n || !ee_oe_n)) chk(0, "R4", "strobe unqualified", 1, 0);
      // R5: read cycle shape and address
      if (!ee_oe_n && (ee_ce_n || !ee_we_n)) chk(0, "R5", "read strobes", 1, 0);
      if (!ee_oe_n && ee_addr != exp_poll_addr)
        chk(0, "R5", "poll address", ee_addr, exp_poll_addr);
      if (!ee_oe_n && prev_oe && busy_cnt != 0) tog = ~tog;
      // write strobe timing (R2)
      if (prev_we && !ee_we_n) begin
        we_falls++;
        lat_addr = ee_addr[8:0];
        if (pre_cnt != SETUP) chk(0, "R2", "address setup", pre_cnt, SETUP);
        if (in_xfer && have_fall && gap_cnt >= LOADLIM)
          chk(0, "R9", "strobe spacing", gap_cnt, LOADLIM - 1);
        have_fall = 1;
        gap_cnt = 0;
        low_cnt = 0;
      end
      if (!ee_we_n) low_cnt++;
      if (!prev_we && ee_we_n) begin
        if (low_cnt != PULSE) chk(0, "R2", "strobe width", low_cnt, PULSE);
        if (!ee_dq_oe) chk(0, "R4", "data held after strobe", 0, 1);
        mem[lat_addr] = ee_dq_out;
        last_data = ee_dq_out;
        busy_cnt = busy_len;
        after_rise = 1;
        hold_cnt = 0;
      end
      if (after_rise && !ee_ce_n) hold_cnt++;
      if (ee_ce_n && !prev_ce && after_rise) begin
        if (hold_cnt != HOLD) chk(0, "R2", "hold time", hold_cnt, HOLD);
        after_rise = 0;
      end
      if (ee_ce_n) pre_cnt = 0;
      else if (ee_we_n && !after_rise) pre_cnt++;
      prev_we = ee_we_n;
      prev_oe = ee_oe_n;
      prev_ce = ee_ce_n;
    end
  end

  // ---------------- transfer driver ----------------
  logic [7:0] exp_data [0:255];
  bit  xfer_end;
  bit  r_done, r_err;
  int  r_code, r_busy_at_end, r_idle_since, r_cycles;

  task automatic wait_model_idle();
    while (busy_cnt != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [ADDR_W-1:0] a, input int n, input logic md,
                          input int stall_idx, input int stall_len, input int busy,
                          input bit poke);
    wait_model_idle();
    busy_len      = busy;
    exp_poll_addr = a + ADDR_W'(n - 1);
    have_fall     = 0;
    in_xfer       = 1;
    xfer_end      = 0;
    req_valid  = 1'b1;
    req_addr   = a;
    req_len_m1 = PAGE_B'(n - 1);
    poll_mode  = md;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    fork
      begin : feeder
        for (int i = 0; i < n; i++) begin
          if (xfer_end) break;
          if (i == stall_idx) begin
            byte_valid = 1'b0;
            repeat (stall_len) @(negedge clk);
          end
          byte_valid = 1'b1;
          byte_data  = exp_data[i];
          while (!byte_ready && !xfer_end) @(negedge clk);
          if (xfer_end) break;
          @(negedge clk);
        end
        byte_valid = 1'b0;
      end
      begin : waiter
        r_cycles = 0;
        while (!(done || err_valid) && r_cycles < 20000) begin
          @(negedge clk);
          r_cycles++;
        end
        if (r_cycles >= 20000) chk(0, "R11", "transfer end watchdog", 0, 1);
        r_done = done;
        r_err  = err_valid;
        r_code = err_code;
        r_busy_at_end = busy_cnt;
        r_idle_since  = idle_cnt;
        xfer_end = 1;
        @(negedge clk);
        if (r_done) chk(done == 1'b0, "R11", "done single cycle", done, 0);
        if (r_err)  chk(err_valid == 1'b0, "R11", "error single cycle", err_valid, 0);
      end
      begin : poker
        if (poke) begin
          repeat (6) @(negedge clk);
          req_valid  = 1'b1;
          req_addr   = 17'h00100;
          req_len_m1 = 8'd0;
          for (int k = 0; k < 10; k++) begin
            chk(req_ready == 1'b0, "R12", "ready low while busy", req_ready, 0);
            @(negedge clk);
          end
          req_valid = 1'b0;
        end
      end
    join
    in_xfer = 0;
  endtask

  task automatic fill_pattern(input int seed, input int n);
    for (int i = 0; i < n; i++) exp_data[i] = 8'((i * 37 + seed) & 255);
  endtask

  task automatic check_mem(input logic [ADDR_W-1:0] a, input int n, input string rq);
    int bad = 0;
    int first_bad = -1;
    for (int i = 0; i < n; i++)
      if (mem[(a[8:0] + 9'(i))] !== exp_data[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    chk(bad == 0, rq, "bytes stored at start plus index", bad, 0);
  endtask

  task automatic check_done_ok(input string rq);
    chk(r_done && !r_err, rq, "done raised", r_done, 1);
    chk(r_busy_at_end == 0, rq, "done not before device idle", r_busy_at_end, 0);
    chk(r_idle_since <= 16, rq, "done soon after device idle", r_idle_since, 16);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({ee_ce_n, ee_oe_n, ee_we_n} == 3'b111, "R1", "strobes idle", {ee_ce_n, ee_oe_n, ee_we_n}, 7);
    chk(ee_dq_oe == 1'b0, "R1", "drivers off", ee_dq_oe, 0);
    chk(done == 1'b0 && err_valid == 1'b0, "R1", "no pulses", {done, err_valid}, 0);
  endtask

  task automatic t_single_bit7();
    int f0;
    exp_data[0] = 8'h3C;
    f0 = we_falls;
    run_xfer(17'h00020, 1, 1'b0, -1, 0, 60, 0);
    check_done_ok("R6");
    chk(we_falls - f0 == 1, "R3", "one byte for count field 0", we_falls - f0, 1);
    check_mem(17'h00020, 1, "R2");
    exp_data[0] = 8'hC3;
    run_xfer(17'h00021, 1, 1'b0, -1, 0, 45, 0);
    check_done_ok("R6");
    check_mem(17'h00021, 1, "R2");
  endtask

  task automatic t_page_bit6();
    fill_pattern(11, 4);
    run_xfer(17'h00044, 4, 1'b1, -1, 0, 70, 0);
    check_done_ok("R7");
    check_mem(17'h00044, 4, "R2");
  endtask

  task automatic t_full_page();
    int f0;
    fill_pattern(5, 256);
    f0 = we_falls;
    run_xfer(17'h00100, 256, 1'b0, -1, 0, 50, 0);
    check_done_ok("R6");
    chk(we_falls - f0 == 256, "R3", "256 bytes for count field 255", we_falls - f0, 256);
    check_mem(17'h00100, 256, "R3");
  endtask

  task automatic t_page_cross(input logic [ADDR_W-1:0] a, input int lm1,
                              input bit expect_err);
    int f0;
    wait_model_idle();
    f0 = we_falls;
    req_valid  = 1'b1;
    req_addr   = a;
    req_len_m1 = PAGE_B'(lm1);
    poll_mode  = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (expect_err) begin
      chk(err_valid == 1'b1 && err_code == 2'd1, "R8", "refused one cycle after accept",
          {err_valid, err_code}, 5);
      repeat (20) @(negedge clk);
      chk(we_falls == f0, "R8", "no strobe for refused request", we_falls - f0, 0);
      chk(req_ready == 1'b1, "R8", "idle after refusal", req_ready, 1);
    end else begin
      chk(err_valid == 1'b0 && req_ready == 1'b0, "R8", "last byte of page accepted",
          {err_valid, req_ready}, 0);
      // complete it as a normal one-byte transfer
      exp_poll_addr = a;
      busy_len = 30;
      byte_valid = 1'b1;
      byte_data  = 8'h7E;
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
      while (!(done || err_valid)) @(negedge clk);
      chk(done == 1'b1, "R8", "edge request completes", done, 1);
      chk(mem[a[8:0]] == 8'h7E, "R2", "edge byte stored", mem[a[8:0]], 8'h7E);
    end
  endtask

  task automatic t_underrun();
    logic [7:0] keep;
    fill_pattern(90, 3);
    keep = mem[9'h0C1];
    mem[9'h0C1] = ~exp_data[1];
    run_xfer(17'h000C0, 3, 1'b0, 1, 100, 60, 0);
    chk(r_err && r_code == 2, "R9", "underrun code", r_code, 2);
    chk(mem[9'h0C1] == ~exp_data[1], "R9", "late byte not written", mem[9'h0C1], ~exp_data[1]);
    mem[9'h0C1] = keep;
    fill_pattern(120, 3);
    run_xfer(17'h000D0, 3, 1'b1, 1, 20, 60, 0);
    check_done_ok("R9");
    check_mem(17'h000D0, 3, "R9");
  endtask

  task automatic t_timeout();
    fill_pattern(3, 2);
    run_xfer(17'h00060, 2, 1'b0, -1, 0, 2000, 0);
    chk(r_err && r_code == 3, "R10", "timeout code", r_code, 3);
    chk(r_busy_at_end != 0, "R10", "device still busy at timeout", r_busy_at_end, 1);
    chk(r_cycles >= POLLLIM, "R10", "not before poll limit", r_cycles, POLLLIM);
  endtask

  task automatic t_ignored_request();
    mem[9'h100] = 8'hEE;
    fill_pattern(200, 8);
    run_xfer(17'h00080, 8, 1'b1, -1, 0, 40, 1);
    check_done_ok("R12");
    check_mem(17'h00080, 8, "R12");
    chk(mem[9'h100] == 8'hEE, "R12", "ignored request wrote nothing", mem[9'h100], 8'hEE);
  endtask

  initial begin
    req_valid = 0; req_addr = '0; req_len_m1 = '0; poll_mode = 0;
    byte_valid = 0; byte_data = '0; last_data = '0; lat_addr = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_bit7();
    t_page_bit6();
    t_full_page();
    t_page_cross(17'h001F0, 16, 1);
    t_page_cross(17'h001FF, 1, 1);
    t_page_cross(17'h001FF, 0, 0);
    t_underrun();
    t_timeout();
    t_ignored_request();
    wait_model_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule